// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a memory-mapped watchdog peripheral. A 32-bit counter runs down once per clock. When it reaches zero it reloads from a programmable load register. The first expiry raises an interrupt. If that interrupt has not been serviced by the next expiry, the block pulses a system reset output. Software keeps the system alive by clearing the interrupt, or by rewriting the load value, before the second expiry.

The register bus carries one access per cycle: an address, a write strobe, write data and combinational read data. Every register except the lock register is write-protected until a 32-bit key is written to the lock register. Any other value written there protects the registers again.

Top module: `dual_expiry_wdog`

## Requirements
- R1: Register offsets: load 0x000, current count 0x004, control 0x008, interrupt clear 0x00C, raw status 0x010, masked status 0x014, lock 0xC00. A read of any other offset returns 0. Status is in bit 0 of each status register.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks writes. Writing any other value there locks them. The lock register reads 1 when locked and 0 when unlocked. While locked, writes to every other register have no effect.
- R3: When control bit 0 is 1, the count falls by one each cycle. When it is 0, the count holds its value.
- R4: The cycle in which an enabled count is zero is an expiry. An expiry sets the raw interrupt and reloads the count from the load register. If the count reads V, the raw interrupt rises after V+1 rising edges.
- R5: If the raw interrupt is already set at an expiry and control bit 1 is 1, the reset output rises. Without intervention, and with no interrupt pending when the count reads V, the reset output rises after V+L+2 edges, where L is the load value.
- R6: The reset output is high for exactly one cycle. It never rises while control bit 1 is 0.
- R7: A write of any value to offset 0x00C clears the raw interrupt. Masked status equals raw status AND control bit 0. The interrupt output drives the masked status.
- R8: A write to offset 0x000 sets the load register and, at the same edge, the count. A written value of 0 is stored as 1, so the load range is 1 to 0xFFFFFFFF.
- R9: After reset, load and count are 0xFFFFFFFF, control is 0, the raw interrupt and the reset output are 0, and the block is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Register byte offset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data |
| irqOut | output | 1 | Masked interrupt |
| sysRstOut | output | 1 | One-cycle system reset pulse |

## Verification
A wrong count or reload value shows up as the interrupt or the reset edge moving by a whole number of cycles. The checks place each of these edges exactly, for load values 1 to 8. A stale lock or control bit shows up on the next read-back of the register, or as a reset pulse that should not occur within one timeout period. A pending interrupt that is not cleared correctly turns a serviced timeout into a reset on the very next expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned WD_DATA_W = 32;
  localparam int unsigned WD_ADDR_W = 12;
  localparam logic [WD_ADDR_W-1:0] OFS_LOAD  = 12'h000;
  localparam logic [WD_ADDR_W-1:0] OFS_COUNT = 12'h004;
  localparam logic [WD_ADDR_W-1:0] OFS_CTRL  = 12'h008;
  localparam logic [WD_ADDR_W-1:0] OFS_CLR   = 12'h00C;
  localparam logic [WD_ADDR_W-1:0] OFS_RAW   = 12'h010;
  localparam logic [WD_ADDR_W-1:0] OFS_MASK  = 12'h014;
  localparam logic [WD_ADDR_W-1:0] OFS_LOCK  = 12'hC00;
  localparam logic [WD_DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

  // Strobes from the register side to the counting side
  typedef struct packed {
    logic reload;
    logic clrIrq;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = WD_DATA_W,
  parameter int unsigned ADDR_W = WD_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] cntVal,
  input  logic              rawIrq,
  output wdStrobe_t         strb,
  output logic [DATA_W-1:0] loadNext,
  output logic              enCnt,
  output logic              enRst
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [DATA_W-1:0] ONE_VAL  = DATA_W'(1);

  logic [DATA_W-1:0] loadReg;
  logic [1:0]        ctrlReg;
  logic              locked;
  logic              wrOpen;
  logic [DATA_W-1:0] clampedWr;

  assign wrOpen    = busWrEn && !locked;
  assign clampedWr = (busWrData == '0) ? ONE_VAL : busWrData;

  always_comb begin
    strb.reload = wrOpen && (busAddr == OFS_LOAD);
    strb.clrIrq = wrOpen && (busAddr == OFS_CLR);
    loadNext    = strb.reload ? clampedWr : loadReg;
  end

  assign enCnt = ctrlReg[0];
  assign enRst = ctrlReg[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadReg <= ALL_ONES;
      ctrlReg <= 2'b00;
      locked  <= 1'b1;
    end else begin
      if (busWrEn && busAddr == OFS_LOCK) locked <= (busWrData != UNLOCK_KEY);
      if (strb.reload) loadReg <= clampedWr;
      if (wrOpen && busAddr == OFS_CTRL) ctrlReg <= busWrData[1:0];
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      OFS_LOAD:  busRdData = loadReg;
      OFS_COUNT: busRdData = cntVal;
      OFS_CTRL:  busRdData[1:0] = ctrlReg;
      OFS_RAW:   busRdData[0] = rawIrq;
      OFS_MASK:  busRdData[0] = rawIrq & ctrlReg[0];
      OFS_LOCK:  busRdData[0] = locked;
      default:   busRdData = '0;
    endcase
  end

  // R2
  locked_load_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !(busWrEn && busAddr == OFS_LOCK)) |=> ($stable(loadReg) && $stable(ctrlReg)));
  // R8
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadReg != '0);
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = WD_DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdStrobe_t         strb,
  input  logic [DATA_W-1:0] loadNext,
  input  logic              enCnt,
  input  logic              enRst,
  output logic [DATA_W-1:0] cntVal,
  output logic              rawIrq,
  output logic              rstPulse
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic expire;
  assign expire = enCnt && !strb.reload && (cntVal == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal   <= ALL_ONES;
      rawIrq   <= 1'b0;
      rstPulse <= 1'b0;
    end else begin
      if (strb.reload)            cntVal <= loadNext;
      else if (expire)            cntVal <= loadNext;
      else if (enCnt)             cntVal <= cntVal - 1'b1;
      if (expire)                 rawIrq <= 1'b1;
      else if (strb.clrIrq)       rawIrq <= 1'b0;
      rstPulse <= expire && rawIrq && enRst && !strb.clrIrq;
    end
  end

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enCnt && !strb.reload) |=> $stable(cntVal));
  // R5
  rst_needs_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |-> $past(rawIrq));
  // R6
  rst_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |-> $past(enRst));
  // R6
  rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |=> !rstPulse);
endmodule

// File: rtl/dual_expiry_wdog.sv
module dual_expiry_wdog
  import wdog_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WD_ADDR_W-1:0] busAddr,
  input  logic                 busWrEn,
  input  logic [WD_DATA_W-1:0] busWrData,
  output logic [WD_DATA_W-1:0] busRdData,
  output logic                 irqOut,
  output logic                 sysRstOut
);
  wdStrobe_t            strb;
  logic [WD_DATA_W-1:0] loadNext;
  logic [WD_DATA_W-1:0] cntVal;
  logic                 enCnt, enRst, rawIrq;

  wdog_regs #(.DATA_W(WD_DATA_W), .ADDR_W(WD_ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .cntVal(cntVal),
    .rawIrq(rawIrq), .strb(strb), .loadNext(loadNext),
    .enCnt(enCnt), .enRst(enRst));

  wdog_count #(.DATA_W(WD_DATA_W)) u_count (
    .clk(clk), .rstN(rstN), .strb(strb), .loadNext(loadNext),
    .enCnt(enCnt), .enRst(enRst), .cntVal(cntVal), .rawIrq(rawIrq),
    .rstPulse(sysRstOut));

  assign irqOut = rawIrq & enCnt;
endmodule

// File: tb/dual_expiry_wdog_bench.sv
module dual_expiry_wdog_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut, sysRstOut;
  int errors = 0;
  int checks = 0;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  always #4 clk = ~clk;

  dual_expiry_wdog u_dual_expiry_wdog (.clk(clk), .rstN(rstN), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut), .sysRstOut(sysRstOut));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdData;
  endtask

  task automatic step; @(posedge clk); #1; endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, rc;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R9 reset state, R1 map
    rd(12'h000, v); chk("R9 load", v, 32'hFFFFFFFF);
    rd(12'h004, v); chk("R9 count", v, 32'hFFFFFFFF);
    rd(12'h008, v); chk("R9 ctrl", v, 0);
    rd(12'h010, v); chk("R9 raw", v, 0);
    rd(12'hC00, v); chk("R9 locked", v, 1);
    chk("R9 reset out", {31'b0, sysRstOut}, 0);
    rd(12'h020, v); chk("R1 unmapped", v, 0);
    // R2 locked writes ignored
    wr(12'h000, 5); wr(12'h008, 3);
    rd(12'h000, v); chk("R2 locked load", v, 32'hFFFFFFFF);
    rd(12'h008, v); chk("R2 locked ctrl", v, 0);
    wr(12'hC00, KEY); rd(12'hC00, v); chk("R2 unlocked", v, 0);
    wr(12'hC00, 1); rd(12'hC00, v); chk("R2 relocked", v, 1);
    wr(12'h008, 2); rd(12'h008, v); chk("R2 relocked ctrl", v, 0);
    wr(12'hC00, KEY);
    // R8 reload and clamp
    wr(12'h000, 100); wr(12'h008, 1);
    wr(12'h000, 3); rd(12'h004, v); chk("R8 immediate reload", v, 3);
    wr(12'h008, 0);
    wr(12'h000, 0); rd(12'h000, v); chk("R8 zero clamp", v, 1);
    // R4/R5 sweep of load values
    for (int L = 1; L <= 8; L++) begin
      wr(12'h008, 0); wr(12'h00C, 0); wr(12'h000, L); wr(12'h008, 3);
      n = 0;
      while (!irqOut && n < 100) begin step(); n++; end
      chk($sformatf("R4 irq edges L=%0d", L), n, L + 1);
      while (!sysRstOut && n < 100) begin step(); n++; end
      chk($sformatf("R5 reset edges L=%0d", L), n, 2 * L + 2);
      step(); chk("R6 one cycle", {31'b0, sysRstOut}, 0);
    end
    // R5 remaining-time formula
    wr(12'h008, 0); wr(12'h00C, 0); wr(12'h000, 6); wr(12'h008, 3);
    step(); step(); rd(12'h004, v); chk("R3 decrement", v, 4);
    n = 0;
    while (!sysRstOut && n < 100) begin step(); n++; end
    chk("R5 V+L+2", n, 4 + 6 + 2);
    // R7 clear averts reset
    wr(12'h008, 0); wr(12'h00C, 0); wr(12'h000, 4); wr(12'h008, 3);
    n = 0;
    while (!irqOut && n < 100) begin step(); n++; end
    wr(12'h00C, 32'h12345678);
    rd(12'h010, v); chk("R7 raw cleared", v, 0);
    chk("R7 irq cleared", {31'b0, irqOut}, 0);
    rc = 0; n = 0;
    while (!irqOut && n < 100) begin if (sysRstOut) rc++; step(); n++; end
    chk("R7 no reset after clear", rc, 0);
    chk("R4 irq again", {31'b0, irqOut}, 1);
    // R6 reset disabled
    wr(12'h008, 0); wr(12'h00C, 0); wr(12'h000, 3); wr(12'h008, 1);
    rc = 0;
    for (int i = 0; i < 20; i++) begin step(); if (sysRstOut) rc++; end
    chk("R6 no reset when bit1 clear", rc, 0);
    chk("R7 irq pending", {31'b0, irqOut}, 1);
    // R7 masking and R3 hold
    wr(12'h008, 0);
    chk("R7 irq masked", {31'b0, irqOut}, 0);
    rd(12'h010, v); chk("R7 raw kept", v, 1);
    rd(12'h014, v); chk("R7 masked reg", v, 0);
    rd(12'h004, v);
    begin
      logic [31:0] v2;
      repeat (5) step();
      rd(12'h004, v2); chk("R3 hold", v2, v);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule